// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address. It reads a page table that is stored in memory as a tree with three levels. The caller supplies four things: the physical page number of the root table, a virtual address, the kind of access and the privilege mode. The walker then reads one 64-bit entry for each level through a request/response memory port. Each read goes out only after the previous one has answered.

A walk ends in one of two ways. It can return a 56-bit physical address, made from the leaf entry's page number and the untouched 12-bit page offset. Or it can raise a fault, when an entry is missing, has a bad shape, or does not grant the access. The result comes back as a pulse one cycle long. The walker takes new work only while it is idle.

Entry bit layout: valid bit 0, read bit 1, write bit 2, execute bit 3, user bit 4. The physical page number sits in bits 53:10. Access type encoding on `req_acc_i`: 0 is a data read, 1 is a data write, 2 is an instruction fetch, and 3 is reserved.

Top module: `pt_walker`

## Requirements
- R1: Bits 63:39 of `req_vaddr_i` have no effect on any fetch address or on the result.
- R2: The first fetch goes to `{base_ppn_i, va[38:30], 3'b000}`. The second fetch goes to `{ppn_of_first_entry, va[29:21], 3'b000}`. The third fetch goes to `{ppn_of_second_entry, va[20:12], 3'b000}`. Every fetch address is aligned to 8 bytes.
- R3: On success, `done_paddr_o` equals `{leaf_ppn, va[11:0]}`.
- R4: A successful walk makes exactly three memory reads. A new read is issued only after the previous response has arrived. The next read goes out in the cycle after a response, and `done_o` rises in the cycle after the final response.
- R5: If an entry with the valid bit clear appears at any level, the walk faults and no further read is issued.
- R6: An entry fetched at the first or second level that has the read bit or the execute bit set causes a fault, because large pages are not handled.
- R7: A third-level entry with both the read bit and the execute bit clear causes a fault.
- R8: A data read needs the read bit, a data write needs the write bit, and a fetch needs the execute bit in the leaf entry. Access code 3 always faults.
- R9: A user-mode access to a leaf whose user bit is clear faults. A supervisor access may use a leaf whose user bit is set.
- R10: `req_ready_o` is high only when the walker is idle. A request presented while a walk is running is ignored.
- R11: `done_o` is a pulse one cycle long. `done_fault_o` is high only together with `done_o`. `done_paddr_o` is zero on a fault.
- R12: After reset, `req_ready_o` is 1, and both `done_o` and `mem_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_ppn_i | input | 44 | Page number of the root table |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker is idle and will take a request |
| req_vaddr_i | input | 64 | Virtual address |
| req_acc_i | input | 2 | Access type (0 read, 1 write, 2 fetch) |
| req_user_i | input | 1 | 1 for user mode, 0 for supervisor mode |
| mem_req_o | output | 1 | Entry read strobe, one cycle long |
| mem_addr_o | output | 56 | Entry read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read data |
| done_o | output | 1 | Walk finished, pulse one cycle long |
| done_fault_o | output | 1 | Walk ended in a page fault |
| done_paddr_o | output | 56 | Translated physical address |

## Verification
The bench memory answers each read one cycle after its strobe. With that memory, `done_o` is due in the 7th cycle after the accepting edge for a full walk. It is due in the 3rd cycle when the walk faults on the root entry, and in the 5th cycle when it faults on the middle entry. After the accepting edge, the bench counts falling edges and waits for `done_o`. It then compares that count against the cycle expected for the level where the walk should stop. It also compares the number of reads issued and the logged fetch addresses. All outputs are sampled on the falling edge, so every registered result has settled before it is read.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  localparam int unsigned VA_IN_W = 64;
  localparam int unsigned LEVELS  = 3;
  localparam int unsigned IDX_W   = 9;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned PPN_W   = 44;
  localparam int unsigned PTE_W   = 64;
  localparam int unsigned PTE_LG  = 3;
  localparam int unsigned VA_W    = OFF_W + LEVELS * IDX_W;
  localparam int unsigned PA_W    = PPN_W + OFF_W;
  localparam int unsigned LVL_W   = $clog2(LEVELS);

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef struct packed {
    logic [9:0]       rsvd;
    logic [PPN_W-1:0] ppn;
    logic [1:0]       sw;
    logic             dirty;
    logic             accessed;
    logic             global_m;
    logic             user;
    logic             exec;
    logic             write;
    logic             read;
    logic             valid;
  } pte_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } st_e;
endpackage

// File: rtl/ptw_vpn_slice.sv
`timescale 1ns/1ps
module ptw_vpn_slice #(
  parameter int unsigned LEVELS = 3,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFF_W  = 12,
  localparam int unsigned VA_W  = OFF_W + LEVELS * IDX_W,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_arr [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = vaddr_i[OFF_W + g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level_i == LVL_W'(i)) idx_o = idx_arr[i];
    end
  end
endmodule

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen #(
  parameter int unsigned PPN_W  = 44,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PTE_LG = 3,
  localparam int unsigned OFF_W = IDX_W + PTE_LG,
  localparam int unsigned PA_W  = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PA_W-1:0]  addr_o
);
  // table base is page aligned, so index*entry_size never carries into ppn
  assign addr_o = {ppn_i, idx_i, {PTE_LG{1'b0}}};
endmodule

// File: rtl/ptw_pte_check.sv
`timescale 1ns/1ps
module ptw_pte_check
  import ptw_pkg::*;
(
  input  pte_t pte_i,
  input  logic leaf_lvl_i,
  input  acc_e acc_i,
  input  logic user_i,
  output logic fault_o,
  output logic descend_o
);
  logic is_leaf_fmt;
  logic perm_ok;

  assign is_leaf_fmt = pte_i.read | pte_i.exec;

  always_comb begin
    unique case (acc_i)
      ACC_LOAD:  perm_ok = pte_i.read;
      ACC_STORE: perm_ok = pte_i.write;
      ACC_FETCH: perm_ok = pte_i.exec;
      default:   perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    fault_o   = 1'b0;
    descend_o = 1'b0;
    if (!pte_i.valid) begin
      fault_o = 1'b1;
    end else if (!leaf_lvl_i) begin
      // large pages unsupported: leaf shape above last level faults
      if (is_leaf_fmt) fault_o = 1'b1;
      else             descend_o = 1'b1;
    end else begin
      if (!is_leaf_fmt)              fault_o = 1'b1;
      else if (!perm_ok)             fault_o = 1'b1;
      else if (user_i && !pte_i.user) fault_o = 1'b1;
    end
  end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import ptw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PPN_W-1:0]   base_ppn_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_IN_W-1:0] req_vaddr_i,
  input  logic [1:0]         req_acc_i,
  input  logic               req_user_i,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [PTE_W-1:0]   mem_rsp_data_i,
  output logic               done_o,
  output logic               done_fault_o,
  output logic [PA_W-1:0]    done_paddr_o
);
  st_e              state_q;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  logic             user_q;
  logic [PPN_W-1:0] ppn_q;
  logic [LVL_W-1:0] lvl_q;
  logic             fault_q;
  logic [PA_W-1:0]  paddr_q;

  logic [IDX_W-1:0] idx;
  pte_t             pte;
  logic             chk_fault;
  logic             chk_descend;
  logic             leaf_lvl;

  assign pte      = pte_t'(mem_rsp_data_i);
  assign leaf_lvl = (lvl_q == '0);

  logic unused_bits;
  assign unused_bits = ^{req_vaddr_i[VA_IN_W-1:VA_W], pte.rsvd, pte.sw,
                         pte.dirty, pte.accessed, pte.global_m};

  ptw_vpn_slice #(
    .LEVELS (LEVELS),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
  ) u_slice (
    .vaddr_i (va_q),
    .level_i (lvl_q),
    .idx_o   (idx)
  );

  ptw_addr_gen #(
    .PPN_W  (PPN_W),
    .IDX_W  (IDX_W),
    .PTE_LG (PTE_LG)
  ) u_addr (
    .ppn_i  (ppn_q),
    .idx_i  (idx),
    .addr_o (mem_addr_o)
  );

  ptw_pte_check u_check (
    .pte_i      (pte),
    .leaf_lvl_i (leaf_lvl),
    .acc_i      (acc_q),
    .user_i     (user_q),
    .fault_o    (chk_fault),
    .descend_o  (chk_descend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= ACC_LOAD;
      user_q  <= 1'b0;
      ppn_q   <= '0;
      lvl_q   <= '0;
      fault_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q    <= req_vaddr_i[VA_W-1:0];
            acc_q   <= acc_e'(req_acc_i);
            user_q  <= req_user_i;
            ppn_q   <= base_ppn_i;
            lvl_q   <= LVL_W'(LEVELS - 1);
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid_i) begin
            if (chk_fault) begin
              fault_q <= 1'b1;
              paddr_q <= '0;
              state_q <= ST_DONE;
            end else if (chk_descend) begin
              ppn_q   <= pte.ppn;
              lvl_q   <= lvl_q - 1'b1;
              state_q <= ST_ISSUE;
            end else begin
              fault_q <= 1'b0;
              paddr_q <= {pte.ppn, va_q[OFF_W-1:0]};
              state_q <= ST_DONE;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_req_o    = (state_q == ST_ISSUE);
  assign done_o       = (state_q == ST_DONE);
  assign done_fault_o = done_o & fault_q;
  assign done_paddr_o = done_o ? paddr_q : '0;
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        mem_req_o,
  input logic [55:0] mem_addr_o,
  input logic        done_o,
  input logic        done_fault_o
);
  logic [2:0] rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rd_cnt <= '0;
    else if (req_valid_i && req_ready_o) rd_cnt <= '0;
    else if (mem_req_o)                 rd_cnt <= 3'(rd_cnt + 1'b1);
  end

  // R10
  mem_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  // R4
  one_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R4
  rd_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (rd_cnt < 3'd3));

  // R4
  full_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !done_fault_o) |-> (rd_cnt == 3'd3));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

  // R11
  fault_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_fault_o |-> done_o);

  // R2
  pte_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .done_o       (done_o),
  .done_fault_o (done_fault_o)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  localparam logic [43:0] BASE = 44'h100;
  localparam logic [43:0] MID  = 44'h200;
  localparam logic [43:0] LOW  = 44'h300;
  localparam logic [43:0] LEAF = 44'hABCDE;
  localparam logic [7:0] F_V = 8'h01, F_R = 8'h02, F_W = 8'h04, F_X = 8'h08, F_U = 8'h10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [43:0] base_ppn_i = BASE;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [63:0] req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        req_user_i = 1'b0;
  logic        mem_req_o;
  logic [55:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        done_o;
  logic        done_fault_o;
  logic [55:0] done_paddr_o;

  int tests = 0;
  int fails = 0;
  int fetch_cnt = 0;
  logic [55:0] fetch_log [16];
  logic [63:0] mem [logic [55:0]];

  always #10 clk_i = ~clk_i;

  pt_walker u0 (.*);

  always @(posedge clk_i) begin
    mem_rsp_valid_i <= mem_req_o;
    if (mem_req_o) begin
      mem_rsp_data_i <= mem.exists(mem_addr_o) ? mem[mem_addr_o] : 64'h0;
      fetch_log[fetch_cnt % 16] <= mem_addr_o;
      fetch_cnt <= fetch_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'h0, ppn, 2'b00, fl};
  endfunction

  function automatic logic [55:0] ent(input logic [43:0] ppn, input logic [8:0] idx);
    return {ppn, idx, 3'b000};
  endfunction

  localparam logic [8:0]  I2 = 9'h1A5, I1 = 9'h033, I0 = 9'h1FF;
  localparam logic [11:0] OFS = 12'h7C4;
  localparam logic [63:0] VA = {25'h0, I2, I1, I0, OFS};
  localparam logic [55:0] PA_OK = {LEAF, OFS};

  task automatic build(input logic [7:0] f2, input logic [7:0] f1, input logic [7:0] f0);
    mem.delete();
    mem[ent(BASE, I2)] = mk_pte(MID, f2);
    mem[ent(MID, I1)]  = mk_pte(LOW, f1);
    mem[ent(LOW, I0)]  = mk_pte(LEAF, f0);
  endtask

  task automatic walk(input logic [63:0] va, input logic [1:0] acc, input logic usr,
                      output logic flt, output logic [55:0] pa, output int nrd, output int lat);
    int start;
    start = fetch_cnt;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; req_acc_i = acc; req_user_i = usr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
    flt = done_fault_o;
    pa  = done_paddr_o;
    nrd = fetch_cnt - start;
  endtask

  task automatic t_reset;
    chk(req_ready_o == 1'b1, "R12 ready", 64'(req_ready_o), 64'd1);
    chk(done_o == 1'b0, "R12 done", 64'(done_o), 64'd0);
    chk(mem_req_o == 1'b0, "R12 mem_req", 64'(mem_req_o), 64'd0);
  endtask

  task automatic t_basic;
    logic f; logic [55:0] pa; int n, l, s;
    build(F_V, F_V, F_V | F_R | F_W);
    s = fetch_cnt;
    walk(VA, 2'd0, 1'b0, f, pa, n, l);
    chk(!f, "R3 no fault", 64'(f), 64'd0);
    chk(pa == PA_OK, "R3 paddr", 64'(pa), 64'(PA_OK));
    chk(n == 3, "R4 read count", 64'(n), 64'd3);
    chk(l == 7, "R4 latency", 64'(l), 64'd7);
    chk(fetch_log[s % 16] == ent(BASE, I2), "R2 root addr", 64'(fetch_log[s % 16]), 64'(ent(BASE, I2)));
    chk(fetch_log[(s+1) % 16] == ent(MID, I1), "R2 mid addr", 64'(fetch_log[(s+1) % 16]), 64'(ent(MID, I1)));
    chk(fetch_log[(s+2) % 16] == ent(LOW, I0), "R2 leaf addr", 64'(fetch_log[(s+2) % 16]), 64'(ent(LOW, I0)));
    @(negedge clk_i);
    chk(done_o == 1'b0, "R11 pulse width", 64'(done_o), 64'd0);
  endtask

  task automatic t_upper;
    logic f; logic [55:0] pa; int n, l;
    build(F_V, F_V, F_V | F_R);
    walk({25'h1ABCDEF, VA[38:0]}, 2'd0, 1'b0, f, pa, n, l);
    chk(!f && pa == PA_OK, "R1 upper bits ignored", 64'(pa), 64'(PA_OK));
  endtask

  task automatic t_perm;
    logic f; logic [55:0] pa; int n, l;
    build(F_V, F_V, F_V | F_R | F_W);
    walk(VA, 2'd1, 1'b0, f, pa, n, l);
    chk(!f && pa == PA_OK, "R8 write on RW", 64'(f), 64'd0);
    walk(VA, 2'd2, 1'b0, f, pa, n, l);
    chk(f, "R8 fetch on RW", 64'(f), 64'd1);
    chk(pa == 56'h0, "R11 paddr zero on fault", 64'(pa), 64'd0);
    build(F_V, F_V, F_V | F_R);
    walk(VA, 2'd1, 1'b0, f, pa, n, l);
    chk(f, "R8 write on RO", 64'(f), 64'd1);
    build(F_V, F_V, F_V | F_X);
    walk(VA, 2'd2, 1'b0, f, pa, n, l);
    chk(!f && pa == PA_OK, "R8 fetch on X", 64'(f), 64'd0);
    walk(VA, 2'd0, 1'b0, f, pa, n, l);
    chk(f, "R8 read on X-only", 64'(f), 64'd1);
    build(F_V, F_V, F_V | F_R | F_W | F_X);
    walk(VA, 2'd3, 1'b0, f, pa, n, l);
    chk(f, "R8 reserved access", 64'(f), 64'd1);
  endtask

  task automatic t_user;
    logic f; logic [55:0] pa; int n, l;
    build(F_V, F_V, F_V | F_R);
    walk(VA, 2'd0, 1'b1, f, pa, n, l);
    chk(f, "R9 user on S page", 64'(f), 64'd1);
    build(F_V, F_V, F_V | F_R | F_U);
    walk(VA, 2'd0, 1'b1, f, pa, n, l);
    chk(!f && pa == PA_OK, "R9 user on U page", 64'(f), 64'd0);
    walk(VA, 2'd0, 1'b0, f, pa, n, l);
    chk(!f && pa == PA_OK, "R9 supervisor on U page", 64'(f), 64'd0);
  endtask

  task automatic t_invalid;
    logic f; logic [55:0] pa; int n, l;
    build(8'h0, F_V, F_V | F_R);
    walk(VA, 2'd0, 1'b0, f, pa, n, l);
    chk(f && n == 1 && l == 3, "R5 root invalid", 64'({f, 8'(n), 8'(l)}), 64'({1'b1, 8'd1, 8'd3}));
    build(F_V, 8'h0, F_V | F_R);
    walk(VA, 2'd0, 1'b0, f, pa, n, l);
    chk(f && n == 2 && l == 5, "R5 mid invalid", 64'({f, 8'(n), 8'(l)}), 64'({1'b1, 8'd2, 8'd5}));
    build(F_V, F_V, F_R | F_W);
    walk(VA, 2'd0, 1'b0, f, pa, n, l);
    chk(f && n == 3, "R5 leaf invalid", 64'({f, 8'(n)}), 64'({1'b1, 8'd3}));
  endtask

  task automatic t_large;
    logic f; logic [55:0] pa; int n, l;
    build(F_V | F_R, F_V, F_V | F_R);
    walk(VA, 2'd0, 1'b0, f, pa, n, l);
    chk(f && n == 1, "R6 root leaf shape", 64'({f, 8'(n)}), 64'({1'b1, 8'd1}));
    build(F_V, F_V | F_X, F_V | F_R);
    walk(VA, 2'd2, 1'b0, f, pa, n, l);
    chk(f && n == 2, "R6 mid leaf shape", 64'({f, 8'(n)}), 64'({1'b1, 8'd2}));
  endtask

  task automatic t_ptr_leaf;
    logic f; logic [55:0] pa; int n, l;
    build(F_V, F_V, F_V | F_W);
    walk(VA, 2'd1, 1'b0, f, pa, n, l);
    chk(f && n == 3, "R7 pointer at last level", 64'({f, 8'(n)}), 64'({1'b1, 8'd3}));
  endtask

  task automatic t_busy;
    int s, cyc;
    logic busy_ok;
    build(F_V, F_V, F_V | F_R);
    mem[ent(BASE, 9'h001)] = mk_pte(MID, F_V);
    s = fetch_cnt;
    busy_ok = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = VA; req_acc_i = 2'd0; req_user_i = 1'b0;
    @(negedge clk_i);
    req_vaddr_i = {25'h0, 9'h001, 9'h0, 9'h0, 12'h0};
    cyc = 0;
    while (!done_o && cyc < 40) begin
      if (req_ready_o) busy_ok = 1'b0;
      @(negedge clk_i);
      cyc++;
    end
    req_valid_i = 1'b0;
    chk(busy_ok, "R10 ready low while busy", 64'(busy_ok), 64'd1);
    chk(done_paddr_o == PA_OK, "R10 first request kept", 64'(done_paddr_o), 64'(PA_OK));
    chk(fetch_cnt - s == 3, "R10 no extra walk", 64'(fetch_cnt - s), 64'd3);
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R11 ready after done", 64'(req_ready_o), 64'd1);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_upper();
    t_perm();
    t_user();
    t_invalid();
    t_large();
    t_ptr_leaf();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule